// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Latch

This block is the slave side of a two-wire serial memory. It holds 128 bytes in a register array. The clock and data lines come in as raw levels and are oversampled on the system clock. The only output is an open-drain pull-down request for the data line. The block finds bus start and stop conditions and checks the control byte against a fixed device code. It keeps a 7-bit address pointer and handles byte writes, page writes, current-address reads, random reads and sequential reads.

Written bytes first collect in an eight-byte page latch. A stop condition then starts a self-timed programming cycle, which runs for a set number of system clocks and copies the latched bytes into the array when it ends. A write-enable level input gates programming. While a cycle runs, the block ignores its own control byte, so a master can poll for completion by watching for the acknowledge.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A stop that arrives after two or more bits of a data byte abandons the write, and no programming cycle follows.
- R2: The control byte is sent MSB first. Its upper seven bits must be 1010000. Bit 0 selects the direction (1 = read, 0 = write). A matching byte is acknowledged by pulling the data line low during the ninth clock. Any other byte gets no acknowledge, and the block stays silent until the next start.
- R3: In a write, the byte after the control byte loads the address pointer from its low 7 bits. Every later byte is a data byte, and each one is acknowledged.
- R4: After each data byte only the pointer's low 3 bits advance, wrapping inside the 8-byte page while the upper 4 bits stay fixed. When more than 8 data bytes arrive, the later bytes replace the earlier ones at the same page offsets.
- R5: A stop after at least one whole data byte starts a programming cycle of WR_CYCLES system clocks, and the array changes only when that cycle ends. Only page offsets that received data are changed. A write that ends with no data byte sets the pointer and starts no cycle.
- R6: While a programming cycle runs, a matching control byte is not acknowledged.
- R7: Programming takes place only when the write-enable level is high at the stop. A write-enable level that drops during a running cycle does not cancel it.
- R8: A current-address read returns the byte at the pointer and then advances the pointer by one, wrapping from 127 to 0. After a read the pointer therefore holds the last address accessed plus one.
- R9: In a read, each master acknowledge (data line low in the ninth clock) makes the block send the next byte. A master non-acknowledge ends the transfer, and the data line is released.
- R10: A random read is a write that sets the pointer, followed by a repeated start and a read control byte, and it returns the byte at the address that was set.
- R11: The pull-down output changes only while the clock line is low.
- R12: After reset the pull-down is released, every array byte is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| wp_level_i | input | 1 | Write-enable level; high allows programming |
| sda_pull_o | output | 1 | 1 requests the data line be pulled low |

## Verification
The assertions check on every cycle that the pull-down moves only while the synchronized clock is low, and that no acknowledge is given to a control byte during a programming cycle. They also check that a cycle starts only from a stop seen with write enable high, that the cycle counter stays within its length, that page data stays in one page, and that the array never commits an empty mask. Only the bench scenarios can show the values themselves. These are the stored contents after page wrap and overwrite, sequential and current-address read order with pointer wrap, the effect of a stop mid-byte, the write-enable gating, and acknowledge polling across a full programming cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } phase_e;

    typedef enum logic [1:0] {
        ROLE_CTRL,
        ROLE_ADDR,
        ROLE_DATA
    } role_e;

    parameter logic [6:0] CTRL_CODE = 7'b1010000;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
    logic                   scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
            scl_prev_q <= scl_sync_q[SYNC_STAGES-1];
            sda_prev_q <= sda_sync_q[SYNC_STAGES-1];
        end
    end

    assign scl_lvl_o  = scl_sync_q[SYNC_STAGES-1];
    assign sda_lvl_o  = sda_sync_q[SYNC_STAGES-1];
    assign scl_rise_o = scl_lvl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_lvl_o & scl_prev_q;
    // data edges count as bus conditions only with the clock high on both samples
    assign start_o    = scl_lvl_o & scl_prev_q & sda_prev_q & ~sda_lvl_o;
    assign stop_o     = scl_lvl_o & scl_prev_q & ~sda_prev_q & sda_lvl_o;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]      page_i,
    input  logic [(1<<PAGE_W)-1:0]        mask_i,
    input  logic [(1<<PAGE_W)*DATA_W-1:0] latch_i,
    input  logic [ADDR_W-1:0]             raddr_i,
    output logic [DATA_W-1:0]             rdata_o
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        localparam int OFS = g % PAGE_BYTES;
        localparam int PG  = g / PAGE_BYTES;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (commit_i && (page_i == (ADDR_W-PAGE_W)'(PG)) && mask_i[OFS]) begin
                mem_q[g] <= latch_i[OFS*DATA_W +: DATA_W];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R5
    commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (mask_i != '0));
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int WR_CYCLES   = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_level_i,
    output logic sda_pull_o
);
    import eep_pkg::*;

    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int CW         = $clog2(WR_CYCLES + 1);
    localparam logic [PAGE_W-1:0] OFS_ONE = 1;
    localparam logic [ADDR_W-1:0] PTR_ONE = 1;

    typedef struct packed {
        phase_e                         st;
        role_e                          role;
        logic                           rw;
        logic                           mack;
        logic [3:0]                     bitcnt;
        logic [DATA_W-1:0]              sh;
        logic [ADDR_W-1:0]              ptr;
        logic                           drive;
        logic [PAGE_BYTES-1:0]          pend;
        logic [PAGE_BYTES*DATA_W-1:0]   latch;
        logic                           busy;
        logic [CW-1:0]                  cnt;
        logic [PG_W-1:0]                page;
    } regs_t;

    regs_t q, d;
    logic  scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic  commit;
    logic [DATA_W-1:0] rdata;
    logic [PAGE_W-1:0] ofs;

    eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(ev_start), .stop_o(ev_stop)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(q.page),
        .mask_i(q.pend), .latch_i(q.latch), .raddr_i(q.ptr), .rdata_o(rdata)
    );

    assign ofs = q.ptr[PAGE_W-1:0];

    always_comb begin
        d      = q;
        commit = 1'b0;
        // self-timed programming cycle
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                commit = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        if (ev_start) begin
            d.st     = ST_RX;
            d.role   = ROLE_CTRL;
            d.bitcnt = '0;
            d.drive  = 1'b0;
            if (!q.busy) d.pend = '0;
        end else if (ev_stop) begin
            // the stop's own clock rise has already counted one bit
            if (q.st == ST_RX && q.role == ROLE_DATA && q.bitcnt <= 4'd1 &&
                q.pend != '0 && wp_level_i && !q.busy) begin
                d.busy = 1'b1;
                d.cnt  = CW'(WR_CYCLES - 1);
                d.page = q.ptr[ADDR_W-1:PAGE_W];
            end
            d.st     = ST_IDLE;
            d.drive  = 1'b0;
            d.bitcnt = '0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh     = {q.sh[DATA_W-2:0], sda_lvl};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        d.drive  = 1'b1;
                        d.st     = ST_RXACK;
                        unique case (q.role)
                            ROLE_CTRL: begin
                                if (q.sh[7:1] == CTRL_CODE && !q.busy) begin
                                    d.rw = q.sh[0];
                                end else begin
                                    d.drive = 1'b0;
                                    d.st    = ST_IDLE;
                                end
                            end
                            ROLE_ADDR: begin
                                d.ptr  = q.sh[ADDR_W-1:0];
                                d.pend = '0;
                            end
                            default: begin
                                d.latch[ofs*DATA_W +: DATA_W] = q.sh;
                                d.pend[ofs] = 1'b1;
                                d.ptr = {q.ptr[ADDR_W-1:PAGE_W], ofs + OFS_ONE};
                            end
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        if (q.role == ROLE_CTRL && q.rw) begin
                            d.sh     = rdata;
                            d.drive  = ~rdata[DATA_W-1];
                            d.ptr    = q.ptr + PTR_ONE;
                            d.bitcnt = '0;
                            d.st     = ST_TX;
                        end else begin
                            d.drive = 1'b0;
                            d.st    = ST_RX;
                            d.role  = (q.role == ROLE_CTRL) ? ROLE_ADDR : ROLE_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.drive  = 1'b0;
                            d.bitcnt = '0;
                            d.st     = ST_TXACK;
                        end else begin
                            d.sh    = {q.sh[DATA_W-2:0], 1'b0};
                            d.drive = ~q.sh[DATA_W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh     = rdata;
                            d.drive  = ~rdata[DATA_W-1];
                            d.ptr    = q.ptr + PTR_ONE;
                            d.bitcnt = '0;
                            d.st     = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.role <= ROLE_CTRL;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.drive;

    // R11
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_lvl);
    // R6
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RXACK && q.role == ROLE_CTRL) |-> !q.busy);
    // R5
    cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt < CW'(WR_CYCLES)));
    // R7
    wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> ($past(wp_level_i) && $past(ev_stop)));
    // R4
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && q.role == ROLE_DATA) |=>
        (q.ptr[ADDR_W-1:PAGE_W] == $past(q.ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
    localparam int WRC  = 300;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic wp = 1'b1;
    logic pull;
    wire  sda_line = msda & ~pull;

    int tests = 0;
    int fails = 0;
    int viol  = 0;
    bit done  = 1'b0;
    logic prev_pull = 1'b0;
    logic [7:0] ref_mem [128];

    always #5 clk = ~clk;

    serial_eeprom_slave #(.WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .wp_level_i(wp), .sda_pull_o(pull)
    );

    always @(negedge clk) begin
        if (rst_n && (pull != prev_pull) && scl) viol++;
        prev_pull <= pull;
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        msda = 1'b1; waitc(HALF);
        scl  = 1'b1; waitc(HALF);
        msda = 1'b0; waitc(HALF);
        scl  = 1'b0; waitc(HALF);
    endtask

    task automatic bus_stop;
        msda = 1'b0; waitc(HALF);
        scl  = 1'b1; waitc(HALF);
        msda = 1'b1; waitc(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            msda = b[i]; waitc(HALF);
            scl  = 1'b1; waitc(HALF);
            scl  = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        msda = 1'b1; waitc(HALF);
        scl  = 1'b1; waitc(HALF/2);
        ack  = ~sda_line; waitc(HALF/2);
        scl  = 1'b0;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(HALF);
            scl = 1'b1; waitc(HALF/2);
            b[i] = sda_line; waitc(HALF/2);
            scl = 1'b0;
        end
        msda = ~mack; waitc(HALF);
        scl  = 1'b1; waitc(HALF);
        scl  = 1'b0; waitc(2);
        msda = 1'b1;
    endtask

    task automatic poll(output bit ack);
        bus_start;
        send_byte(8'hA0, ack);
        bus_stop;
    endtask

    task automatic rand_read(input logic [6:0] a, output logic [7:0] b);
        bit ack;
        bus_start; send_byte(8'hA0, ack); send_byte({1'b0, a}, ack);
        bus_start; send_byte(8'hA1, ack);
        read_byte(1'b0, b);
        bus_stop;
    endtask

    task automatic cur_read(output logic [7:0] b);
        bit ack;
        bus_start; send_byte(8'hA1, ack);
        read_byte(1'b0, b);
        bus_stop;
    endtask

    function automatic logic [7:0] pat(input int p, input int k);
        return 8'((p * 37 + k * 11 + 5) & 255);
    endfunction

    initial begin
        bit ack, allack, got;
        logic [7:0] b;
        int n;
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        chk(pull == 1'b0, "R12 pull released", int'(pull), 0);

        // page writes: start at offset 3, send 10 bytes so two wrap and overwrite
        for (int p = 0; p < 16; p++) begin
            allack = 1'b1;
            bus_start;
            send_byte(8'hA0, ack); allack &= ack;
            send_byte(8'(p * 8 + 3), ack); allack &= ack;
            for (int k = 0; k < 10; k++) begin
                send_byte(pat(p, k), ack); allack &= ack;
                ref_mem[p * 8 + ((3 + k) % 8)] = pat(p, k);
            end
            bus_stop;
            chk(allack, "R3 write bytes acked", int'(allack), 1);
            poll(ack);
            if (p == 0) chk(!ack, "R6 no ack during cycle", int'(ack), 0);
            got = ack; n = 0;
            while (!got && n < 20) begin poll(got); n++; end
            chk(got, "R5 cycle ends and ack returns", int'(got), 1);
        end

        // random read of address 0, then sequential through whole array
        bus_start; send_byte(8'hA0, ack); send_byte(8'h00, ack);
        bus_start; send_byte(8'hA1, ack);
        chk(ack, "R10 read control acked", int'(ack), 1);
        for (int a = 0; a < 128; a++) begin
            read_byte(a != 127, b);
            chk(b == ref_mem[a], "R4 R9 R10 stored data", int'(b), int'(ref_mem[a]));
        end
        waitc(4);
        chk(pull == 1'b0, "R9 released after nack", int'(pull), 0);
        bus_stop;
        cur_read(b);
        chk(b == ref_mem[0], "R8 pointer wrap 127 to 0", int'(b), int'(ref_mem[0]));
        cur_read(b);
        chk(b == ref_mem[1], "R8 current address plus one", int'(b), int'(ref_mem[1]));

        // write-enable low: no cycle, no change
        wp = 1'b0;
        bus_start; send_byte(8'hA0, ack); send_byte(8'h05, ack); send_byte(8'h5A, ack);
        bus_stop;
        poll(ack);
        chk(ack, "R7 no cycle when wp low", int'(ack), 1);
        rand_read(7'h05, b);
        chk(b == ref_mem[5], "R7 data kept when wp low", int'(b), int'(ref_mem[5]));

        // write-enable drops during a cycle: still programs
        wp = 1'b1;
        bus_start; send_byte(8'hA0, ack); send_byte(8'h09, ack); send_byte(8'hC3, ack);
        bus_stop;
        wp = 1'b0;
        waitc(WRC + 50);
        wp = 1'b1;
        ref_mem[9] = 8'hC3;
        rand_read(7'h09, b);
        chk(b == 8'hC3, "R7 wp drop does not cancel", int'(b), 'hC3);

        // zero-data write sets the pointer only
        bus_start; send_byte(8'hA0, ack); send_byte(8'h40, ack);
        bus_stop;
        poll(ack);
        chk(ack, "R5 no cycle without data", int'(ack), 1);
        bus_start; send_byte(8'hA0, ack); send_byte(8'h40, ack);
        bus_stop;
        cur_read(b);
        chk(b == ref_mem[64], "R3 pointer loaded", int'(b), int'(ref_mem[64]));

        // stop in the middle of a data byte abandons the write
        bus_start; send_byte(8'hA0, ack); send_byte(8'h10, ack);
        send_bits(8'hFF, 4);
        bus_stop;
        poll(ack);
        chk(ack, "R1 mid-byte stop starts no cycle", int'(ack), 1);
        rand_read(7'h10, b);
        chk(b == ref_mem[16], "R1 mid-byte stop keeps data", int'(b), int'(ref_mem[16]));

        // control byte sweep
        for (int c = 0; c < 256; c++) begin
            bus_start;
            send_byte(8'(c), ack);
            chk(ack == (c[7:1] == 7'b1010000), "R2 control decode", int'(ack),
                int'(c[7:1] == 7'b1010000));
            if (c == 'hA1) read_byte(1'b0, b);
            bus_stop;
        end

        chk(viol == 0, "R11 pull moves only with clock low", viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule